// File: doc/BRIEF.md
# Compute-and-Branch Loop Counter Unit

This unit is the slice of a branch stage that retires loop-control instructions. A single instruction adjusts a counter register by an immediate and, in the same cycle, decides whether to jump back to the loop head. Short loops therefore spend one instruction per iteration on loop control rather than an arithmetic step followed by a separate conditional branch. A companion immediate-load form seeds the counter before the loop starts.

Counters are kept per hardware thread. Each thread owns its own small bank of counter registers, selected by a thread index and a register index carried with the instruction. The unit receives an already decoded instruction: a valid flag, an operation code, thread and register indices, an immediate, the current program counter and a jump target. Within that cycle it presents the updated counter value, the write enable and the next program counter. The counter bank takes the new value at the following rising clock edge. Instruction decode, pipelining and hazard handling are left to the surrounding core.

Top module: `loop_cbr_unit`

## Requirements
- R1: After synchronous reset every counter of every thread reads as zero.
- R2: The load form (`in_op` = 2'b01) writes the immediate into the selected counter, shows the immediate on `out_result`, does not branch, and sets the next PC to PC+1.
- R3: The decrement-and-jump form (`in_op` = 2'b10) writes the counter minus the immediate back into the same counter.
- R4: For either jump form, a nonzero updated counter asserts `out_taken` and sets `out_next_pc` to `in_target` in the same cycle as the write.
- R5: For either jump form, an updated counter of zero deasserts `out_taken` and sets `out_next_pc` to `in_pc` + 1.
- R6: The increment-and-jump form (`in_op` = 2'b11) writes the counter plus the immediate, modulo 2^DATA_W, and follows the rules of R4 and R5.
- R7: Decrementing a counter that holds zero by one gives all ones, and the branch is taken.
- R8: A write changes only the addressed register of the addressed thread; the same register index in other threads keeps its value.
- R9: With `in_valid` low, or with `in_op` = 2'b00, nothing is written, `out_wr_en` and `out_taken` are low, and the next PC is PC+1.
- R10: A counter loaded with 0x0A and decremented by one per iteration branches on nine iterations and falls through on the tenth.
- R11: A value written in one cycle is the operand seen by an instruction on the same counter in the next cycle.
- R12: The sequential next PC wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 2 | 00 idle, 01 load, 10 decrement-and-jump, 11 increment-and-jump |
| in_thread | input | TID_W | Thread index |
| in_reg | input | RID_W | Counter register index within the thread |
| in_imm | input | DATA_W | Immediate operand |
| in_target | input | PC_W | Jump target address |
| in_pc | input | PC_W | Address of the current instruction |
| out_taken | output | 1 | Jump taken |
| out_next_pc | output | PC_W | Next program counter |
| out_result | output | DATA_W | Updated counter value |
| out_wr_en | output | 1 | Counter write this cycle |

## Verification
The bench builds the unit with eight threads, four counters per thread, and both DATA_W and PC_W set to 8. The 8-bit counter makes the wrap from zero to 0xFF and the add-overflow to zero reachable with small immediates. The 8-bit PC lets a single instruction at address 0xFF exercise the sequential wrap to zero. Eight threads give the highest thread index and its isolation from thread zero on the same register index.

// File: rtl/loop_cbr_pkg.sv
package loop_cbr_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_LDI  = 2'b01,
        OP_DECJ = 2'b10,
        OP_INCJ = 2'b11
    } cbr_op_e;

    function automatic logic op_writes(cbr_op_e op);
        return op != OP_IDLE;
    endfunction

    function automatic logic op_jumps(cbr_op_e op);
        return (op == OP_DECJ) || (op == OP_INCJ);
    endfunction

    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/loop_cnt_bank.sv
module loop_cnt_bank #(
    parameter int unsigned THREADS = 8,
    parameter int unsigned REGS    = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned TID_W   = loop_cbr_pkg::idx_width(THREADS),
    parameter int unsigned RID_W   = loop_cbr_pkg::idx_width(REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TID_W-1:0]  rd_thr,
    input  logic [RID_W-1:0]  rd_reg,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [TID_W-1:0]  wr_thr,
    input  logic [RID_W-1:0]  wr_reg,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int unsigned ENTRIES = THREADS * REGS;
    localparam int unsigned AW      = loop_cbr_pkg::idx_width(ENTRIES) + 1;

    logic [DATA_W-1:0] cells [ENTRIES];
    logic [AW-1:0]     rd_idx;
    logic [AW-1:0]     wr_idx;

    always_comb begin
        rd_idx = AW'(rd_thr) * AW'(REGS) + AW'(rd_reg);
        wr_idx = AW'(wr_thr) * AW'(REGS) + AW'(wr_reg);
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[e] <= '0;
            end else if (wr_en && (wr_idx == AW'(e))) begin
                cells[e] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (rd_idx == AW'(e)) begin
                rd_data = cells[e];
            end
        end
    end
endmodule

// File: rtl/loop_cnt_alu.sv
module loop_cnt_alu #(
    parameter int unsigned DATA_W = 16
) (
    input  loop_cbr_pkg::cbr_op_e op,
    input  logic [DATA_W-1:0]     cur,
    input  logic [DATA_W-1:0]     imm,
    output logic [DATA_W-1:0]     res,
    output logic                  nonzero
);
    import loop_cbr_pkg::*;

    always_comb begin
        unique case (op)
            OP_LDI:  res = imm;
            OP_DECJ: res = cur - imm;
            OP_INCJ: res = cur + imm;
            default: res = cur;
        endcase
        nonzero = |res;
    end
endmodule

// File: rtl/loop_pc_sel.sv
module loop_pc_sel #(
    parameter int unsigned PC_W = 16
) (
    input  logic            jump_op,
    input  logic            nonzero,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] target,
    output logic            taken,
    output logic [PC_W-1:0] next_pc
);
    logic [PC_W-1:0] seq_pc;

    always_comb begin
        seq_pc  = pc + PC_W'(1);
        taken   = jump_op && nonzero;
        next_pc = taken ? target : seq_pc;
    end
endmodule

// File: rtl/loop_cbr_unit.sv
module loop_cbr_unit #(
    parameter int unsigned THREADS = 8,
    parameter int unsigned REGS    = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned PC_W    = 16,
    parameter int unsigned TID_W   = loop_cbr_pkg::idx_width(THREADS),
    parameter int unsigned RID_W   = loop_cbr_pkg::idx_width(REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [TID_W-1:0]  in_thread,
    input  logic [RID_W-1:0]  in_reg,
    input  logic [DATA_W-1:0] in_imm,
    input  logic [PC_W-1:0]   in_target,
    input  logic [PC_W-1:0]   in_pc,
    output logic              out_taken,
    output logic [PC_W-1:0]   out_next_pc,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wr_en
);
    import loop_cbr_pkg::*;

    typedef struct packed {
        logic              valid;
        cbr_op_e           op;
        logic [TID_W-1:0]  thr;
        logic [RID_W-1:0]  rid;
        logic [DATA_W-1:0] imm;
    } cnt_req_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              nonzero;
        logic              write;
        logic              jump;
    } cnt_rsp_t;

    cnt_req_t          req;
    cnt_rsp_t          rsp;
    logic [DATA_W-1:0] cur_val;
    logic [DATA_W-1:0] alu_res;
    logic              alu_nz;

    always_comb begin
        req.valid = in_valid;
        req.op    = cbr_op_e'(in_op);
        req.thr   = in_thread;
        req.rid   = in_reg;
        req.imm   = in_imm;
    end

    loop_cnt_bank #(
        .THREADS(THREADS), .REGS(REGS), .DATA_W(DATA_W),
        .TID_W(TID_W), .RID_W(RID_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .rd_thr  (req.thr),
        .rd_reg  (req.rid),
        .rd_data (cur_val),
        .wr_en   (rsp.write),
        .wr_thr  (req.thr),
        .wr_reg  (req.rid),
        .wr_data (rsp.value)
    );

    loop_cnt_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (req.op),
        .cur     (cur_val),
        .imm     (req.imm),
        .res     (alu_res),
        .nonzero (alu_nz)
    );

    always_comb begin
        rsp.value   = alu_res;
        rsp.nonzero = alu_nz;
        rsp.write   = req.valid && op_writes(req.op) && !rst;
        rsp.jump    = req.valid && op_jumps(req.op);
    end

    loop_pc_sel #(.PC_W(PC_W)) u_pcsel (
        .jump_op (rsp.jump),
        .nonzero (rsp.nonzero),
        .pc      (in_pc),
        .target  (in_target),
        .taken   (out_taken),
        .next_pc (out_next_pc)
    );

    assign out_result = rsp.value;
    assign out_wr_en  = rsp.write;
endmodule

// File: rtl/loop_cbr_checker.sv
module loop_cbr_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PC_W   = 16,
    parameter int unsigned TID_W  = 3,
    parameter int unsigned RID_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic [TID_W-1:0]  in_thread,
    input logic [RID_W-1:0]  in_reg,
    input logic [DATA_W-1:0] in_imm,
    input logic [PC_W-1:0]   in_target,
    input logic [PC_W-1:0]   in_pc,
    input logic              out_taken,
    input logic [PC_W-1:0]   out_next_pc,
    input logic [DATA_W-1:0] out_result,
    input logic              out_wr_en
);
    logic              jmp;
    logic              prev_wr;
    logic [TID_W-1:0]  prev_thr;
    logic [RID_W-1:0]  prev_reg;
    logic [DATA_W-1:0] prev_res;

    assign jmp = in_valid && in_op[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_wr  <= 1'b0;
            prev_thr <= '0;
            prev_reg <= '0;
            prev_res <= '0;
        end else begin
            prev_wr  <= out_wr_en;
            prev_thr <= in_thread;
            prev_reg <= in_reg;
            prev_res <= out_result;
        end
    end

    assert_load_imm_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b01) |-> (out_result == in_imm && !out_taken
            && out_wr_en && out_next_pc == in_pc + PC_W'(1)));

    assert_jump_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (jmp && out_result != '0) |-> (out_taken && out_next_pc == in_target));

    assert_fall_through_R5: assert property (@(posedge clk) disable iff (rst)
        (jmp && out_result == '0) |-> (!out_taken && out_next_pc == in_pc + PC_W'(1)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || in_op == 2'b00) |-> (!out_taken && !out_wr_en
            && out_next_pc == in_pc + PC_W'(1)));

    assert_wb_visible_R11: assert property (@(posedge clk) disable iff (rst)
        (prev_wr && in_valid && in_op == 2'b11 && in_thread == prev_thr
            && in_reg == prev_reg) |-> (out_result == DATA_W'(prev_res + in_imm)));
endmodule

bind loop_cbr_unit loop_cbr_checker #(
    .DATA_W(DATA_W), .PC_W(PC_W), .TID_W(TID_W), .RID_W(RID_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_thread   (in_thread),
    .in_reg      (in_reg),
    .in_imm      (in_imm),
    .in_target   (in_target),
    .in_pc       (in_pc),
    .out_taken   (out_taken),
    .out_next_pc (out_next_pc),
    .out_result  (out_result),
    .out_wr_en   (out_wr_en)
);

// File: tb/loop_cbr_unit_tb.sv
module loop_cbr_unit_tb;
    localparam int THREADS = 8;
    localparam int REGS    = 4;
    localparam int DW      = 8;
    localparam int PW      = 8;
    localparam int TW      = 3;
    localparam int RW      = 2;

    localparam logic [1:0] OPI = 2'b00, OPL = 2'b01, OPD = 2'b10, OPA = 2'b11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_op = 2'b00;
    logic [TW-1:0] in_thread = '0;
    logic [RW-1:0] in_reg = '0;
    logic [DW-1:0] in_imm = '0;
    logic [PW-1:0] in_target = '0;
    logic [PW-1:0] in_pc = '0;
    logic          out_taken;
    logic [PW-1:0] out_next_pc;
    logic [DW-1:0] out_result;
    logic          out_wr_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    loop_cbr_unit #(
        .THREADS(THREADS), .REGS(REGS), .DATA_W(DW), .PC_W(PW)
    ) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_thread(in_thread), .in_reg(in_reg), .in_imm(in_imm),
        .in_target(in_target), .in_pc(in_pc), .out_taken(out_taken),
        .out_next_pc(out_next_pc), .out_result(out_result), .out_wr_en(out_wr_en)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive after the falling edge, outputs settle 1 ns later; the write lands at the next rising edge.
    task automatic issue(input logic v, input logic [1:0] op, input int thr, input int rg,
                         input int imm, input int tgt, input int pc);
        @(negedge clk);
        in_valid  = v;
        in_op     = op;
        in_thread = TW'(thr);
        in_reg    = RW'(rg);
        in_imm    = DW'(imm);
        in_target = PW'(tgt);
        in_pc     = PW'(pc);
        #1;
    endtask

    task automatic peek(input string req, input int thr, input int rg, input int exp);
        issue(1'b1, OPA, thr, rg, 0, 8'h40, 8'h30);
        check(req, "counter value", int'(out_result), exp);
    endtask

    task automatic t_reset;
        for (int t = 0; t < THREADS; t++) begin
            for (int r = 0; r < REGS; r++) begin
                peek("R1", t, r, 0);
            end
        end
        issue(1'b1, OPA, 0, 0, 0, 8'h40, 8'h30);
        check("R5", "taken on zero", int'(out_taken), 0);
        check("R5", "next pc on zero", int'(out_next_pc), 8'h31);
    endtask

    task automatic t_load;
        issue(1'b1, OPL, 2, 1, 8'h5A, 8'h77, 8'h10);
        check("R2", "load result", int'(out_result), 8'h5A);
        check("R2", "load taken", int'(out_taken), 0);
        check("R2", "load next pc", int'(out_next_pc), 8'h11);
        check("R2", "load write enable", int'(out_wr_en), 1);
        issue(1'b1, OPA, 2, 1, 0, 8'h66, 8'h12);
        check("R4", "nonzero read taken", int'(out_taken), 1);
        check("R4", "next pc is target", int'(out_next_pc), 8'h66);
        check("R2", "loaded value held", int'(out_result), 8'h5A);
    endtask

    task automatic t_loop;
        int taken_cnt = 0;
        issue(1'b1, OPL, 3, 0, 8'h0A, 0, 8'h20);
        for (int i = 1; i <= 10; i++) begin
            issue(1'b1, OPD, 3, 0, 1, 8'h21, 8'h22);
            check("R3", "decremented value (R11 back to back)", int'(out_result), 10 - i);
            if (i < 10) begin
                check("R4", "loop branch target", int'(out_next_pc), 8'h21);
            end else begin
                check("R5", "loop exit pc", int'(out_next_pc), 8'h23);
            end
            if (out_taken) taken_cnt++;
        end
        check("R10", "taken iterations", taken_cnt, 9);
        issue(1'b1, OPD, 3, 0, 3, 8'h21, 8'h22);
        issue(1'b1, OPD, 3, 0, 2, 8'h21, 8'h22);
        check("R3", "decrement by 2 after wrap", int'(out_result), 8'hFB);
    endtask

    task automatic t_add;
        issue(1'b1, OPL, 1, 3, 8'hF0, 0, 8'h50);
        issue(1'b1, OPA, 1, 3, 8'h10, 8'h44, 8'h51);
        check("R6", "add overflow to zero", int'(out_result), 0);
        check("R6", "add zero not taken", int'(out_taken), 0);
        check("R6", "add zero next pc", int'(out_next_pc), 8'h52);
        issue(1'b1, OPA, 1, 3, 3, 8'h44, 8'h53);
        check("R6", "add result", int'(out_result), 3);
        check("R6", "add nonzero taken", int'(out_taken), 1);
        check("R6", "add nonzero target", int'(out_next_pc), 8'h44);
    endtask

    task automatic t_wrap_sub;
        issue(1'b1, OPD, 5, 3, 1, 8'h0C, 8'h60);
        check("R7", "zero minus one", int'(out_result), 8'hFF);
        check("R7", "wrap branch taken", int'(out_taken), 1);
        check("R7", "wrap target", int'(out_next_pc), 8'h0C);
        peek("R7", 5, 3, 8'hFF);
    endtask

    task automatic t_threads;
        issue(1'b1, OPL, 0, 2, 8'h11, 0, 0);
        issue(1'b1, OPL, 7, 2, 8'h77, 0, 0);
        peek("R8", 0, 2, 8'h11);
        peek("R8", 7, 2, 8'h77);
        peek("R8", 1, 2, 0);
        peek("R8", 0, 1, 0);
    endtask

    task automatic t_idle;
        issue(1'b1, OPL, 4, 1, 8'h33, 0, 0);
        issue(1'b0, OPL, 4, 1, 8'h99, 8'h0E, 8'h70);
        check("R9", "invalid write enable", int'(out_wr_en), 0);
        check("R9", "invalid taken", int'(out_taken), 0);
        check("R9", "invalid next pc", int'(out_next_pc), 8'h71);
        issue(1'b1, OPI, 4, 1, 8'h99, 8'h0E, 8'h72);
        check("R9", "idle write enable", int'(out_wr_en), 0);
        check("R9", "idle taken", int'(out_taken), 0);
        check("R9", "idle next pc", int'(out_next_pc), 8'h73);
        peek("R9", 4, 1, 8'h33);
    endtask

    task automatic t_pc_wrap;
        issue(1'b1, OPA, 6, 0, 0, 8'h05, 8'hFF);
        check("R12", "jump fall-through wrap", int'(out_next_pc), 0);
        issue(1'b1, OPL, 6, 1, 8'h02, 8'h05, 8'hFF);
        check("R12", "load next pc wrap", int'(out_next_pc), 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_loop();
        t_add();
        t_wrap_sub();
        t_threads();
        t_idle();
        t_pc_wrap();
        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule